// File: doc/BRIEF.md
# Pipelined 8x8 Compressor-Tree Multiplier

This block multiplies two unsigned 8-bit operands and returns the full 16-bit product. It forms all eight partial-product rows with AND gates in parallel. Two levels of tiled 4-to-2 compressors reduce them to two rows, and a carry-propagate adder then sums those two rows. Each compressor column is built from two chained full adders. Besides its sum and carry, each column passes a lateral carry to the column above it. That lateral carry is formed only from the column's own first three bits, so no carry ripples across a compressor row.

Registers follow each compressor level and the final adder. The block therefore takes one new operand pair on every clock and returns each product exactly three cycles later. A qualifier bit travels through the pipeline next to the data. The surrounding logic drives a valid strobe with both operands and watches for the matching strobe on the product side.

Top module: `mul8_ct`

## Requirements
- R1: While reset (active-low `rst_n`) is asserted, and in the first cycle after its release, `out_valid` is 0 and `out_product` is 0.
- R2: For each accepted pair, `out_product` equals the unsigned product `in_a * in_b` as a 16-bit value.
- R3: A pair presented with `in_valid` = 1 before a rising clock edge appears on the outputs with `out_valid` = 1 after the third rising edge.
- R4: Pairs presented on consecutive cycles come out on consecutive cycles in the same order, with no bubble between them.
- R5: A cycle with `in_valid` = 0 gives `out_valid` = 0 three cycles later, whatever the operand values.
- R6: The corner operands give exact results: 255 x 255 gives 65025, and any pair with a zero operand gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand pair on `in_a`/`in_b` is to be multiplied |
| in_a | input | 8 | Unsigned multiplicand |
| in_b | input | 8 | Unsigned multiplier |
| out_valid | output | 1 | `out_product` holds a result |
| out_product | output | 16 | Unsigned product |

## Verification
The bench builds the block at its default 8-bit operand width. At that width the input space is only 65,536 pairs, so the bench can sweep every pair through the pipeline back-to-back. It inserts an idle cycle after each row of multiplier values, so that gaps and restarts are also seen at the output. The expected product and qualifier are computed by plain multiplication from a three-entry history of the driven inputs. In the checker, the carry-save rows at each register stage are compared with the operand product, so a fault can be located at its compressor level.

// File: rtl/mul8_ct_pkg.sv
package mul8_ct_pkg;
  localparam int unsigned OP_W         = 8;
  localparam int unsigned PROD_W       = 2 * OP_W;
  localparam int unsigned ROWS         = OP_W;
  localparam int unsigned ROWS_PER_CSA = 4;
  localparam int unsigned L1_GROUPS    = ROWS / ROWS_PER_CSA;
  localparam int unsigned L1_ROWS      = 2 * L1_GROUPS;

  typedef logic [OP_W-1:0]   op_t;
  typedef logic [PROD_W-1:0] prod_t;

  // {carry, sum} of three bits
  function automatic logic [1:0] full_add(input logic x, input logic y, input logic z);
    return {(x & y) | (x & z) | (y & z), x ^ y ^ z};
  endfunction

  // partial product row idx, already shifted to its weight
  function automatic prod_t pp_row(input op_t a, input op_t b, input int unsigned idx);
    prod_t r;
    r = prod_t'(a & {OP_W{b[idx]}});
    return r << idx;
  endfunction

  function automatic prod_t add4(input prod_t w, input prod_t x, input prod_t y, input prod_t z);
    return w + x + y + z;
  endfunction
endpackage

// File: rtl/mul8_ct_pparray.sv
module mul8_ct_pparray
  import mul8_ct_pkg::*;
(
  input  op_t                            a,
  input  op_t                            b,
  output logic [ROWS-1:0][PROD_W-1:0]    rows
);
  for (genvar i = 0; i < ROWS; i++) begin : g_row
    assign rows[i] = pp_row(a, b, i);
  end
endmodule

// File: rtl/mul8_ct_csa42_row.sv
module mul8_ct_csa42_row #(
  parameter int unsigned N = 16
) (
  input  logic [N-1:0] in0,
  input  logic [N-1:0] in1,
  input  logic [N-1:0] in2,
  input  logic [N-1:0] in3,
  output logic [N-1:0] sum,
  output logic [N-1:0] carry
);
  import mul8_ct_pkg::full_add;

  // lateral carries between neighbouring columns; top one leaves the word
  logic [N-2:0] lat;

  assign carry[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_col
    logic [1:0] fa_hi;
    logic [1:0] fa_lo;
    logic       lat_in;

    if (i == 0) begin : g_first
      assign lat_in = 1'b0;
    end else begin : g_next
      assign lat_in = lat[i-1];
    end

    // first adder sees only column inputs: lateral out never waits on lateral in
    assign fa_hi  = full_add(in0[i], in1[i], in2[i]);
    assign fa_lo  = full_add(fa_hi[0], in3[i], lat_in);
    assign sum[i] = fa_lo[0];

    if (i < N - 1) begin : g_up
      assign lat[i]     = fa_hi[1];
      assign carry[i+1] = fa_lo[1];
    end
  end
endmodule

// File: rtl/mul8_ct.sv
module mul8_ct
  import mul8_ct_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [OP_W-1:0]   in_a,
  input  logic [OP_W-1:0]   in_b,
  output logic              out_valid,
  output logic [PROD_W-1:0] out_product
);
  logic [ROWS-1:0][PROD_W-1:0]    pp_rows;
  logic [L1_ROWS-1:0][PROD_W-1:0] l1_rows;
  logic [L1_ROWS-1:0][PROD_W-1:0] s1_rows;
  logic                           s1_valid;
  prod_t                          l2_sum, l2_carry;
  prod_t                          s2_sum, s2_carry;
  logic                           s2_valid;
  prod_t                          final_sum;

  mul8_ct_pparray u_pp (
    .a    (in_a),
    .b    (in_b),
    .rows (pp_rows)
  );

  // level 1: each group of four partial-product rows becomes two
  for (genvar g = 0; g < L1_GROUPS; g++) begin : g_lvl1
    mul8_ct_csa42_row #(.N(PROD_W)) u_csa (
      .in0   (pp_rows[ROWS_PER_CSA*g]),
      .in1   (pp_rows[ROWS_PER_CSA*g+1]),
      .in2   (pp_rows[ROWS_PER_CSA*g+2]),
      .in3   (pp_rows[ROWS_PER_CSA*g+3]),
      .sum   (l1_rows[2*g]),
      .carry (l1_rows[2*g+1])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_rows  <= '0;
      s1_valid <= 1'b0;
    end else begin
      s1_rows  <= l1_rows;
      s1_valid <= in_valid;
    end
  end

  // level 2: the four registered rows become two
  mul8_ct_csa42_row #(.N(PROD_W)) u_lvl2 (
    .in0   (s1_rows[0]),
    .in1   (s1_rows[1]),
    .in2   (s1_rows[2]),
    .in3   (s1_rows[3]),
    .sum   (l2_sum),
    .carry (l2_carry)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_sum   <= '0;
      s2_carry <= '0;
      s2_valid <= 1'b0;
    end else begin
      s2_sum   <= l2_sum;
      s2_carry <= l2_carry;
      s2_valid <= s1_valid;
    end
  end

  assign final_sum = s2_sum + s2_carry;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_product <= '0;
      out_valid   <= 1'b0;
    end else begin
      out_product <= final_sum;
      out_valid   <= s2_valid;
    end
  end
endmodule

// File: rtl/mul8_ct_chk.sv
module mul8_ct_chk
  import mul8_ct_pkg::*;
(
  input logic                           clk,
  input logic                           rst_n,
  input logic                           in_valid,
  input logic [OP_W-1:0]                in_a,
  input logic [OP_W-1:0]                in_b,
  input logic                           out_valid,
  input logic [PROD_W-1:0]              out_product,
  input logic [L1_ROWS-1:0][PROD_W-1:0] s1_rows,
  input logic                           s1_valid,
  input logic [PROD_W-1:0]              s2_sum,
  input logic [PROD_W-1:0]              s2_carry,
  input logic                           s2_valid
);
  prod_t in_prod, s1_total, s2_total;
  assign in_prod  = prod_t'(in_a) * prod_t'(in_b);
  assign s1_total = add4(s1_rows[0], s1_rows[1], s1_rows[2], s1_rows[3]);
  assign s2_total = s2_sum + s2_carry;

  AST_L1_ROWS_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid |-> s1_total == $past(in_prod)); // R2
  AST_L2_ROWS_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    s2_valid |-> s2_total == $past(s1_total)); // R2
  AST_OUT_PRODUCT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_product == $past(in_prod, 3)); // R2
  AST_LATENCY_THREE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##3 out_valid); // R3
  AST_IDLE_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> ##3 !out_valid); // R5
  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_n |-> (!out_valid && out_product == '0)); // R1
endmodule

bind mul8_ct mul8_ct_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_a        (in_a),
  .in_b        (in_b),
  .out_valid   (out_valid),
  .out_product (out_product),
  .s1_rows     (s1_rows),
  .s1_valid    (s1_valid),
  .s2_sum      (s2_sum),
  .s2_carry    (s2_carry),
  .s2_valid    (s2_valid)
);

// File: tb/tb_mul8_ct.sv
module tb_mul8_ct;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [7:0]  in_a, in_b;
  logic        out_valid;
  logic [15:0] out_product;

  int checks = 0;
  int errors = 0;

  // inputs driven 1, 2 and 3 negedges ago
  logic       hv [3];
  logic [7:0] ha [3];
  logic [7:0] hb [3];
  logic       prev_out_valid;

  always #2 clk = ~clk;

  mul8_ct dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
    .out_valid(out_valid), .out_product(out_product)
  );

  task automatic report;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic check_outputs;
    logic [15:0] exp;
    checks++;
    if (out_valid !== hv[2]) begin
      errors++;
      if (hv[2] && prev_out_valid)
        $display("FAIL R4 out_valid=%0b expected %0b", out_valid, hv[2]);
      else if (hv[2])
        $display("FAIL R3 out_valid=%0b expected %0b", out_valid, hv[2]);
      else
        $display("FAIL R5 out_valid=%0b expected %0b", out_valid, hv[2]);
    end
    if (hv[2]) begin
      exp = 16'(ha[2]) * 16'(hb[2]);
      checks++;
      if (out_product !== exp) begin
        errors++;
        if ((ha[2] == 8'd255 && hb[2] == 8'd255) || ha[2] == 8'd0 || hb[2] == 8'd0)
          $display("FAIL R6 %0d*%0d product=%0d expected %0d", ha[2], hb[2], out_product, exp);
        else
          $display("FAIL R2 %0d*%0d product=%0d expected %0d", ha[2], hb[2], out_product, exp);
      end
    end
    prev_out_valid = hv[2];
  endtask

  task automatic step(input logic v, input logic [7:0] a, input logic [7:0] b);
    @(negedge clk);
    check_outputs();
    hv[2] = hv[1]; ha[2] = ha[1]; hb[2] = hb[1];
    hv[1] = hv[0]; ha[1] = ha[0]; hb[1] = hb[0];
    hv[0] = v;     ha[0] = a;     hb[0] = b;
    in_valid = v; in_a = a; in_b = b;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish");
    report();
  end

  initial begin
    for (int i = 0; i < 3; i++) begin
      hv[i] = 1'b0; ha[i] = '0; hb[i] = '0;
    end
    prev_out_valid = 1'b0;
    rst_n = 1'b0; in_valid = 1'b0; in_a = 8'hA5; in_b = 8'h5A;
    repeat (3) @(negedge clk);
    // R1: cleared while reset is held, even with operands present
    checks++;
    if (out_valid !== 1'b0 || out_product !== 16'd0) begin
      errors++;
      $display("FAIL R1 valid=%0b product=%0d expected 0 0", out_valid, out_product);
    end
    rst_n = 1'b1;
    in_a = 8'h00; in_b = 8'h00;
    // R1: first cycle after release still clear
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_product !== 16'd0) begin
      errors++;
      $display("FAIL R1 after release valid=%0b product=%0d expected 0 0", out_valid, out_product);
    end
    // R6 corners first, then R2/R4 exhaustive sweep with an R5 gap per row
    step(1'b1, 8'd255, 8'd255);
    step(1'b1, 8'd0,   8'd255);
    step(1'b1, 8'd255, 8'd0);
    step(1'b0, 8'd255, 8'd255);
    for (int a = 0; a < 256; a++) begin
      for (int b = 0; b < 256; b++) begin
        step(1'b1, 8'(a), 8'(b));
      end
      step(1'b0, 8'(a), 8'hFF);
    end
    // drain the pipeline with idle cycles carrying nonzero operands (R5)
    for (int k = 0; k < 5; k++) step(1'b0, 8'hC3, 8'h3C);
    report();
  end
endmodule